// File: doc/BRIEF.md
# Checkpointed Frame Freelist

This block holds the numbers of the call frames that are not in use, in first-in first-out order, for a call-frame controller. The controller takes a frame from the head when it allocates and puts a frame back at the tail when it frees one. The head and tail positions are two 8-bit counters that index a 256-entry internal RAM. Both counters move only on the clock edge that ends an instruction's read phase, marked by `step`.

Speculative work is rolled back after a trap. At every `step` the block saves the counter pair the instruction started with, and it keeps two such saved pairs. Pulsing `rollback` puts the older pair back into the live counters in one cycle. This undoes every allocation and free made by the last two instructions. A software port can read and load both counters, and it can read and write any RAM entry.

After reset the block is in state FILL. In that state it writes entry k with the value k for every k, and it then moves to RUN through the transition FILL_DONE. RUN is held until the next reset. Frame 0 is reserved, so the queue starts with frames 1 to 255. The head counter starts at 1 and the tail counter at 0.

Top module: `frame_freelist`

## Requirements
- R1: After reset the block spends 256 cycles in FILL with `ready` low, then raises `ready`. Entry k then holds k, the head counter is 1, the tail counter is 0, `empty` is 0 and `alloc_frame` shows 1.
- R2: `alloc_frame` always shows the RAM entry at the head. A cycle with `step`, `alloc_req` and a non-empty queue advances the head by one.
- R3: A cycle with `step` and `free_req` writes `free_frame` into the entry at the tail and advances the tail by one. Freed frames come back out in the order they were freed.
- R4: Without `step`, `rollback` or a software counter load, neither counter changes, whatever `alloc_req` and `free_req` do.
- R5: A `rollback` pulse restores both counters to the values they held before the second most recent `step`. `rollback` takes priority over `step` in the same cycle.
- R6: `empty` is 1 exactly when the head equals the tail. A `step` with `alloc_req` while empty leaves the head unchanged and raises `alloc_err` for the following cycle.
- R7: The software port is enabled by `sw_en`, and `sw_sel` selects what it accesses: 0 is the RAM entry at `sw_addr`, 1 is the head counter, 2 is the tail counter. `sw_rdata` shows the selected value combinationally.
- R8: A software write (`sw_we`) to a counter sets the live value and both saved copies, so a `rollback` right after it returns the loaded value. A software RAM write in the same cycle as a free is dropped.
- R9: While `ready` is low, `step`, `rollback` and software writes have no effect on the counters.
- R10: Both counters wrap from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step | input | 1 | End-of-read edge qualifier; counters move and are saved |
| alloc_req | input | 1 | Take the head frame at this step |
| free_req | input | 1 | Return `free_frame` at this step |
| free_frame | input | 8 | Frame number being freed |
| rollback | input | 1 | Restore counters from two instructions back |
| sw_en | input | 1 | Software port enable |
| sw_we | input | 1 | Software write |
| sw_sel | input | 2 | 0 RAM entry, 1 head counter, 2 tail counter |
| sw_addr | input | 8 | RAM entry index for software access |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Software read data |
| alloc_frame | output | 8 | Frame at the head of the queue |
| empty | output | 1 | Head equals tail |
| alloc_err | output | 1 | Allocation attempted while empty (one cycle late) |
| ready | output | 1 | Fill complete, state RUN |

## Verification
The hardest condition to reach from the ports is an empty queue. Reset leaves 255 frames queued, so allocation alone would take hundreds of instructions to drain it. The bench instead loads both counters to the same value through the software port. From there it tries an allocation while empty, does a free that wraps the tail past 255, and then rolls back over a mixed sequence of allocations and frees. This shows that the checkpoint history ignores ordinary stalls and resets correctly on a software load.

// File: rtl/frame_freelist_pkg.sv
package frame_freelist_pkg;
    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } fl_state_e;

    typedef enum logic [1:0] {
        SEL_RAM  = 2'd0,
        SEL_HEAD = 2'd1,
        SEL_TAIL = 2'd2,
        SEL_NONE = 2'd3
    } sw_sel_e;
endpackage

// File: rtl/fl_ckpt_counter.sv
module fl_ckpt_counter #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         adv,
    input  logic         rollback,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value
);
    logic [W-1:0] live_q, prev1_q, prev2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q  <= RST_VAL;
            prev1_q <= RST_VAL;
            prev2_q <= RST_VAL;
        end else if (rollback) begin
            live_q  <= prev2_q;
            prev1_q <= prev2_q;
        end else if (step) begin
            live_q  <= live_q + W'(adv);
            prev1_q <= live_q;
            prev2_q <= prev1_q;
        end else if (load) begin
            live_q  <= load_val;
            prev1_q <= load_val;
            prev2_q <= load_val;
        end
    end

    assign value = live_q;

    // R4: the counter holds when nothing moves it
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !rollback && !load) |=> $stable(value));
    // R5: restore comes from the value seen two steps earlier
    a_r5_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !rollback) ##1 (step && !rollback) ##1 rollback
        |=> value == $past(value, 3));
endmodule

// File: rtl/fl_ram.sv
module fl_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/frame_freelist.sv
module frame_freelist
    import frame_freelist_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             alloc_req,
    input  logic             free_req,
    input  logic [PTR_W-1:0] free_frame,
    input  logic             rollback,
    input  logic             sw_en,
    input  logic             sw_we,
    input  logic [1:0]       sw_sel,
    input  logic [PTR_W-1:0] sw_addr,
    input  logic [PTR_W-1:0] sw_wdata,
    output logic [PTR_W-1:0] sw_rdata,
    output logic [PTR_W-1:0] alloc_frame,
    output logic             empty,
    output logic             alloc_err,
    output logic             ready
);
    localparam logic [PTR_W-1:0] HEAD_RST = PTR_W'(1);
    localparam logic [PTR_W-1:0] TAIL_RST = '0;
    localparam logic [PTR_W-1:0] FILL_END = '1;

    fl_state_e        state_q, state_d;
    logic [PTR_W-1:0] fill_q;
    logic [PTR_W-1:0] head, tail, sw_ram_rd;
    logic             run, rb, stp, pop_ok, push, sw_wr;
    logic             ram_we;
    logic [PTR_W-1:0] ram_waddr, ram_wdata;
    sw_sel_e          sel;

    assign sel = sw_sel_e'(sw_sel);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FILL) fill_q <= fill_q + 1'b1;
        end
    end

    // next state and per-state outputs
    always_comb begin
        state_d   = state_q;
        run       = 1'b0;
        ram_we    = 1'b0;
        ram_waddr = fill_q;
        ram_wdata = fill_q;
        unique case (state_q)
            ST_FILL: begin
                ram_we = 1'b1;
                if (fill_q == FILL_END) state_d = ST_RUN;
            end
            ST_RUN: begin
                run = 1'b1;
                if (push) begin
                    ram_we    = 1'b1;
                    ram_waddr = tail;
                    ram_wdata = free_frame;
                end else if (sw_wr && sel == SEL_RAM) begin
                    ram_we    = 1'b1;
                    ram_waddr = sw_addr;
                    ram_wdata = sw_wdata;
                end
            end
        endcase
    end

    assign empty  = (head == tail);
    assign rb     = run && rollback;
    assign stp    = run && step && !rollback;
    assign pop_ok = stp && alloc_req && !empty;
    assign push   = stp && free_req;
    assign sw_wr  = run && sw_en && sw_we;
    assign ready  = run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) alloc_err <= 1'b0;
        else        alloc_err <= stp && alloc_req && empty;
    end

    fl_ckpt_counter #(.W(PTR_W), .RST_VAL(HEAD_RST)) u_head (
        .clk(clk), .rst_n(rst_n), .step(stp), .adv(pop_ok), .rollback(rb),
        .load(sw_wr && sel == SEL_HEAD), .load_val(sw_wdata), .value(head)
    );

    fl_ckpt_counter #(.W(PTR_W), .RST_VAL(TAIL_RST)) u_tail (
        .clk(clk), .rst_n(rst_n), .step(stp), .adv(push), .rollback(rb),
        .load(sw_wr && sel == SEL_TAIL), .load_val(sw_wdata), .value(tail)
    );

    fl_ram #(.AW(PTR_W), .DW(PTR_W)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr_a(head), .rdata_a(alloc_frame),
        .raddr_b(sw_addr), .rdata_b(sw_ram_rd)
    );

    always_comb begin
        unique case (sel)
            SEL_RAM:  sw_rdata = sw_ram_rd;
            SEL_HEAD: sw_rdata = head;
            SEL_TAIL: sw_rdata = tail;
            default:  sw_rdata = '0;
        endcase
    end

    // R9: counters sit at reset values until the fill finishes
    a_r9_fill_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (head == HEAD_RST && tail == TAIL_RST));
    // R6: a pop on an empty queue leaves the head alone and flags an error
    a_r6_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (stp && alloc_req && empty) |=> (alloc_err && $stable(head)));
    // R2: a successful pop moves the head by exactly one
    a_r2_pop_adv: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ok |=> head == $past(head) + 1'b1);
    // R3: a free moves the tail by exactly one
    a_r3_push_adv: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> tail == $past(tail) + 1'b1);
endmodule

// File: tb/frame_freelist_test.sv
module frame_freelist_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step = 0, alloc_req = 0, free_req = 0, rollback = 0;
    logic       sw_en = 0, sw_we = 0;
    logic [1:0] sw_sel = 0;
    logic [7:0] free_frame = 0, sw_addr = 0, sw_wdata = 0;
    logic [7:0] sw_rdata, alloc_frame;
    logic       empty, alloc_err, ready;
    int         n_chk = 0, n_bad = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    frame_freelist uut (
        .clk(clk), .rst_n(rst_n), .step(step), .alloc_req(alloc_req),
        .free_req(free_req), .free_frame(free_frame), .rollback(rollback),
        .sw_en(sw_en), .sw_we(sw_we), .sw_sel(sw_sel), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .alloc_frame(alloc_frame),
        .empty(empty), .alloc_err(alloc_err), .ready(ready)
    );

    // {alloc, free, free_frame, expected head frame, head after, tail after}
    localparam logic [33:0] VEC [5] = '{
        {1'b1, 1'b0, 8'd0, 8'd1, 8'd2, 8'd0},
        {1'b1, 1'b0, 8'd0, 8'd2, 8'd3, 8'd0},
        {1'b0, 1'b1, 8'd1, 8'd3, 8'd3, 8'd1},
        {1'b1, 1'b1, 8'd2, 8'd3, 8'd4, 8'd2},
        {1'b1, 1'b0, 8'd0, 8'd4, 8'd5, 8'd2}
    };

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic op(input logic a, input logic f, input logic [7:0] fr);
        @(negedge clk);
        step = 1; alloc_req = a; free_req = f; free_frame = fr;
        @(negedge clk);
        step = 0; alloc_req = 0; free_req = 0;
    endtask

    task automatic sw_read(input logic [1:0] s, input logic [7:0] a, output int v);
        @(negedge clk);
        sw_en = 1; sw_we = 0; sw_sel = s; sw_addr = a;
        #1 v = sw_rdata;
        sw_en = 0;
    endtask

    task automatic sw_write(input logic [1:0] s, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sw_en = 1; sw_we = 1; sw_sel = s; sw_addr = a; sw_wdata = d;
        @(negedge clk);
        sw_en = 0; sw_we = 0;
    endtask

    task automatic pulse_rollback();
        @(negedge clk);
        rollback = 1;
        @(negedge clk);
        rollback = 0;
    endtask

    initial begin
        int v;
        #7 rst_n = 1;
        // R9: activity during fill must not move the counters
        @(negedge clk);
        step = 1; alloc_req = 1; free_req = 1; rollback = 0;
        @(negedge clk);
        step = 0; alloc_req = 0; free_req = 0;
        rollback = 1;
        @(negedge clk);
        rollback = 0;
        chk("R9 ready low during fill", int'(ready), 0);
        wait (ready);
        sw_read(2'd1, 0, v); chk("R9 head untouched by fill-time step", v, 1);
        sw_read(2'd2, 0, v); chk("R1 tail after reset", v, 0);
        chk("R1 empty after reset", int'(empty), 0);
        chk("R1 first head frame", int'(alloc_frame), 1);
        sw_read(2'd0, 8'd200, v); chk("R1 R7 entry 200 filled", v, 200);
        sw_read(2'd0, 8'd255, v); chk("R1 entry 255 filled", v, 255);

        // R4: requests without step do nothing
        @(negedge clk);
        alloc_req = 1; free_req = 1;
        repeat (3) @(negedge clk);
        alloc_req = 0; free_req = 0;
        sw_read(2'd1, 0, v); chk("R4 head held without step", v, 1);
        sw_read(2'd2, 0, v); chk("R4 tail held without step", v, 0);

        // R2 R3: table walk
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R2 head frame before step", int'(alloc_frame), int'(VEC[i][23:16]));
            op(VEC[i][33], VEC[i][32], VEC[i][31:24]);
            sw_read(2'd1, 0, v); chk("R2 head after step", v, int'(VEC[i][15:8]));
            sw_read(2'd2, 0, v); chk("R3 tail after step", v, int'(VEC[i][7:0]));
        end
        sw_read(2'd0, 8'd0, v); chk("R3 freed frame stored at slot 0", v, 1);

        // R5: undo the last two instructions
        pulse_rollback();
        sw_read(2'd1, 0, v); chk("R5 head restored", v, 3);
        sw_read(2'd2, 0, v); chk("R5 tail restored", v, 1);

        // R6 R8: make the queue empty through software loads
        sw_write(2'd1, 0, 8'd1);
        sw_write(2'd2, 0, 8'd1);
        chk("R6 empty when equal", int'(empty), 1);
        @(negedge clk);
        step = 1; alloc_req = 1;
        @(negedge clk);
        step = 0; alloc_req = 0;
        chk("R6 alloc_err pulse", int'(alloc_err), 1);
        sw_read(2'd1, 0, v); chk("R6 head unchanged on empty pop", v, 1);
        chk("R6 alloc_err clears", int'(alloc_err), 0);
        op(1'b0, 1'b1, 8'd77);
        chk("R6 not empty after free", int'(empty), 0);
        chk("R3 FIFO returns freed frame", int'(alloc_frame), 77);
        pulse_rollback();
        sw_read(2'd2, 0, v); chk("R8 rollback returns loaded tail", v, 1);

        // R8: software RAM write dropped when a free happens together
        @(negedge clk);
        sw_en = 1; sw_we = 1; sw_sel = 2'd0; sw_addr = 8'd50; sw_wdata = 8'd99;
        step = 1; free_req = 1; free_frame = 8'd5;
        @(negedge clk);
        sw_en = 0; sw_we = 0; step = 0; free_req = 0;
        sw_read(2'd0, 8'd50, v); chk("R8 sw ram write dropped on free", v, 50);

        // R10: wrap
        sw_write(2'd1, 0, 8'd255);
        sw_write(2'd2, 0, 8'd255);
        op(1'b0, 1'b1, 8'd9);
        sw_read(2'd2, 0, v); chk("R10 tail wraps", v, 0);
        chk("R10 wrapped entry at head", int'(alloc_frame), 9);
        op(1'b1, 1'b0, 8'd0);
        sw_read(2'd1, 0, v); chk("R10 head wraps", v, 0);
        chk("R6 empty after draining", int'(empty), 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule